// File: doc/BRIEF.md
# Signed long multiply-accumulate unit

This block is a signed multiply-accumulate datapath with a 64-bit result. Each request carries two 32-bit operands, a 64-bit accumulator split into a low word and a high word, a two-bit mode code, two halfword select bits and a swap bit. The block forms one or two signed products for the chosen mode and adds them to the accumulator. It returns the sum as separate low and high 32-bit words.

Three arithmetic modes are available:

- **Word mode** multiplies the full 32-bit operands.
- **Halfword mode** multiplies one chosen 16-bit half of each operand.
- **Dual mode** adds two 16×16 products. The swap bit selects straight or crossed pairing of the halves.

All sums wrap modulo 2^64. No overflow indication is given.

A request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result is registered and shows up after that edge, together with a one-cycle `out_valid` pulse. The result registers keep their value until the next accepted request.

Top module: `smac_top`

## Requirements
- R1: Mode 2'b00 (word): the result is the 64-bit accumulator plus the product of `op_a` and `op_b`, both read as 32-bit two's complement values.
- R2: The accumulator input and the result are split the same way: the low word carries bits [31:0] and the high word carries bits [63:32].
- R3: Mode 2'b01 (halfword): each operand uses its own select bit, where 0 picks bits [15:0] and 1 picks bits [31:16]. The signed 16×16 product is sign-extended to 64 bits and added to the accumulator.
- R4: In halfword mode, the half of each operand that is not selected has no effect on the result.
- R5: Mode 2'b10 (dual) with `swap` = 0: the result is the accumulator plus a[15:0]×b[15:0] plus a[31:16]×b[31:16], with all halves signed.
- R6: Mode 2'b10 with `swap` = 1: the result is the accumulator plus a[15:0]×b[31:16] plus a[31:16]×b[15:0], with all halves signed.
- R7: Every addition wraps modulo 2^64, with no saturation.
- R8: Mode 2'b11 returns the accumulator unchanged.
- R9: A request is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. After that edge, `out_valid` is high for exactly one cycle for each accepted request. With no accepted request, `out_valid` is low and `res_lo` and `res_hi` hold their value.
- R10: Synchronous active-high reset clears `out_valid`, `res_lo` and `res_hi` to zero. `in_ready` is low while reset is high, so no request is taken during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| mode | input | 2 | 00 word, 01 halfword, 10 dual, 11 pass accumulator |
| sel_a | input | 1 | Halfword mode: 1 picks the top half of op_a, 0 the bottom half |
| sel_b | input | 1 | Halfword mode: 1 picks the top half of op_b, 0 the bottom half |
| swap | input | 1 | Dual mode: crossed pairing of the halves |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| acc_lo | input | 32 | Accumulator bits [31:0] |
| acc_hi | input | 32 | Accumulator bits [63:32] |
| out_valid | output | 1 | One-cycle pulse when a result is new |
| res_lo | output | 32 | Result bits [31:0] |
| res_hi | output | 32 | Result bits [63:32] |

## Verification
The bench builds the block with its default operand width of 32 bits. At that width, the 16-bit and 32-bit most-negative values (0x8000 and 0x80000000) can be driven directly in every mode, and an accumulator of all ones can be pushed across the 64-bit wrap point. Fixed vectors cover these corner values, random requests in all four mode codes are compared against a separate behavioural reference, and directed sequences test how results are held, back-to-back acceptance and reset in the middle of a run.

// File: rtl/smac_pkg.sv
package smac_pkg;
  typedef enum logic [1:0] {
    MODE_WORD = 2'b00,
    MODE_HALF = 2'b01,
    MODE_DUAL = 2'b10,
    MODE_PASS = 2'b11
  } smac_mode_e;
endpackage

// File: rtl/smac_halfsel.sv
module smac_halfsel #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0]    word,
  input  logic               pick_top,
  output logic signed [HW-1:0] half
);
  assign half = pick_top ? word[2*HW-1:HW] : word[HW-1:0];
endmodule

// File: rtl/smac_prod.sv
module smac_prod
  import smac_pkg::*;
#(
  parameter int DW = 32
) (
  input  smac_mode_e       mode,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             swap,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [2*DW-1:0]  term0,
  output logic [2*DW-1:0]  term1
);
  localparam int HW = DW / 2;
  localparam int AW = 2 * DW;

  // full-width signed product
  logic signed [AW-1:0] wa_x, wb_x, p_word;
  assign wa_x   = {{DW{a[DW-1]}}, a};
  assign wb_x   = {{DW{b[DW-1]}}, b};
  assign p_word = wa_x * wb_x;

  // single halfword product with independent selects
  logic signed [HW-1:0] ha, hb;
  logic signed [AW-1:0] ha_x, hb_x, p_half;
  smac_halfsel #(.HW(HW)) u_sel_a (.word(a), .pick_top(sel_a), .half(ha));
  smac_halfsel #(.HW(HW)) u_sel_b (.word(b), .pick_top(sel_b), .half(hb));
  assign ha_x   = {{(AW-HW){ha[HW-1]}}, ha};
  assign hb_x   = {{(AW-HW){hb[HW-1]}}, hb};
  assign p_half = ha_x * hb_x;

  // two lanes for dual mode; lane g takes half g of a, pairing on b set by swap
  logic [AW-1:0] lane_p [2];
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [HW-1:0] la, lb;
    logic signed [AW-1:0] la_x, lb_x, prod;
    logic                 top_a, top_b;
    assign top_a = (g != 0);
    assign top_b = (g != 0) ^ swap;
    smac_halfsel #(.HW(HW)) u_la (.word(a), .pick_top(top_a), .half(la));
    smac_halfsel #(.HW(HW)) u_lb (.word(b), .pick_top(top_b), .half(lb));
    assign la_x = {{(AW-HW){la[HW-1]}}, la};
    assign lb_x = {{(AW-HW){lb[HW-1]}}, lb};
    assign prod = la_x * lb_x;
    assign lane_p[g] = prod;
  end

  always_comb begin
    term0 = '0;
    term1 = '0;
    unique case (mode)
      MODE_WORD: term0 = p_word;
      MODE_HALF: term0 = p_half;
      MODE_DUAL: begin
        term0 = lane_p[0];
        term1 = lane_p[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/smac_acc.sv
module smac_acc #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] t0,
  input  logic [AW-1:0] t1,
  output logic [AW-1:0] sum
);
  // modulo 2^AW: carries out of the top bit are dropped
  assign sum = acc + t0 + t1;
endmodule

// File: rtl/smac_top.sv
module smac_top
  import smac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    mode,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          swap,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] acc_lo,
  input  logic [DW-1:0] acc_hi,
  output logic          out_valid,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi
);
  localparam int AW = 2 * DW;

  logic          accept;
  logic [AW-1:0] acc, t0, t1, sum;
  smac_mode_e    mode_e;

  assign in_ready = ~rst;
  assign accept   = in_valid & in_ready;
  assign acc      = {acc_hi, acc_lo};
  assign mode_e   = smac_mode_e'(mode);

  smac_prod #(.DW(DW)) u_prod (
    .mode(mode_e), .sel_a(sel_a), .sel_b(sel_b), .swap(swap),
    .a(op_a), .b(op_b), .term0(t0), .term1(t1)
  );

  smac_acc #(.AW(AW)) u_acc (.acc(acc), .t0(t0), .t1(t1), .sum(sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        res_lo <= sum[DW-1:0];
        res_hi <= sum[AW-1:DW];
      end
    end
  end

  p_pulse_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!out_valid && $stable({res_hi, res_lo})));

  p_pass_returns_acc_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == 2'b11) |=> ({res_hi, res_lo} == $past({acc_hi, acc_lo})));

  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && res_lo == '0 && res_hi == '0));
endmodule

// File: tb/smac_top_bench.sv
`timescale 1ns/1ps
module smac_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  mode = 2'b00;
  logic        sel_a = 1'b0, sel_b = 1'b0, swap = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc_lo = '0, acc_hi = '0;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  smac_top u_smac_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .sel_a(sel_a), .sel_b(sel_b), .swap(swap),
    .op_a(op_a), .op_b(op_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  // vector: {mode, sel_a, sel_b, swap, a, b, acc}
  localparam int NV = 14;
  localparam logic [132:0] VEC [NV] = '{
    {2'b00, 3'b000, 32'h80000000, 32'h80000000, 64'h0000000000000000},
    {2'b00, 3'b000, 32'h80000000, 32'h7FFFFFFF, 64'h0000000000000005},
    {2'b00, 3'b000, 32'h00000001, 32'h00000001, 64'hFFFFFFFFFFFFFFFF},
    {2'b00, 3'b000, 32'hFFFFFFFF, 32'h00000003, 64'h0000000100000000},
    {2'b01, 3'b010, 32'h00008000, 32'h80000000, 64'h0000000000000000},
    {2'b01, 3'b100, 32'h80000000, 32'h00008000, 64'h1234567800000000},
    {2'b01, 3'b110, 32'h80000000, 32'h80000000, 64'hFFFFFFFFC0000000},
    {2'b01, 3'b000, 32'h00008000, 32'h00007FFF, 64'h0000000000000000},
    {2'b10, 3'b000, 32'h80008000, 32'h80008000, 64'h0000000000000000},
    {2'b10, 3'b001, 32'h80000001, 32'h00028000, 64'h0000000000000000},
    {2'b10, 3'b001, 32'h80008000, 32'h80008000, 64'h7FFFFFFFFFFFFFFF},
    {2'b10, 3'b000, 32'h7FFF8000, 32'h80007FFF, 64'hFFFFFFFF00000000},
    {2'b11, 3'b111, 32'h80000000, 32'h80008000, 64'hDEADBEEF01234567},
    {2'b11, 3'b000, 32'h00008000, 32'h80000000, 64'h0000000000000000}
  };

  function automatic logic [63:0] ref_mac(input logic [1:0] m, input logic sa, input logic sb,
                                          input logic sw, input logic [31:0] a, input logic [31:0] b,
                                          input logic [63:0] acc);
    shortint ab, at, bb, bt, x, y;
    longint  r;
    ab = shortint'(a[15:0]);  at = shortint'(a[31:16]);
    bb = shortint'(b[15:0]);  bt = shortint'(b[31:16]);
    x  = sa ? at : ab;
    y  = sb ? bt : bb;
    case (m)
      2'b00:   r = longint'(int'(a)) * longint'(int'(b));
      2'b01:   r = longint'(x) * longint'(y);
      2'b10:   r = sw ? (longint'(ab) * longint'(bt) + longint'(at) * longint'(bb))
                      : (longint'(ab) * longint'(bb) + longint'(at) * longint'(bt));
      default: r = 0;
    endcase
    return acc + 64'(r);
  endfunction

  function automatic string req_of(input logic [1:0] m, input logic sw);
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R3";
      2'b10:   return sw ? "R6" : "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [132:0] v);
    {mode, sel_a, sel_b, swap, op_a, op_b, acc_hi, acc_lo} = v;
    in_valid = 1'b1;
  endtask

  // called at a falling edge; returns at a falling edge with in_valid low
  task automatic run_op(input logic [132:0] v, input string tag);
    logic [63:0] exp;
    exp = ref_mac(v[132:131], v[130], v[129], v[128], v[127:96], v[95:64], v[63:0]);
    drive(v);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {tag, " R9 out_valid"}, 64'(out_valid), 64'd1);
    check({res_hi, res_lo} === exp, {tag, " R2"}, {res_hi, res_lo}, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0]  held;
    logic [132:0] v;
    logic [132:0] v2;
    logic [63:0]  e1, e2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check(out_valid === 1'b0, "R10 out_valid", 64'(out_valid), 64'd0);
    check({res_hi, res_lo} === 64'd0, "R10 result", {res_hi, res_lo}, 64'd0);
    check(in_ready === 1'b0, "R10 in_ready", 64'(in_ready), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R9 in_ready", 64'(in_ready), 64'd1);

    // table walk: corner values in every mode (R1 R3 R5 R6 R7 R8)
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      run_op(v, req_of(v[132:131], v[128]));
    end
    // R7: wrap case 0xFFFF..FF + 1 -> 0
    run_op(VEC[2], "R7");
    check({res_hi, res_lo} === 64'd0, "R7 wrap", {res_hi, res_lo}, 64'd0);

    // R4: unselected halves changed, result unchanged
    run_op({2'b01, 3'b010, 32'h00008000, 32'h80000000, 64'd7}, "R4 base");
    held = {res_hi, res_lo};
    run_op({2'b01, 3'b010, 32'hABCD8000, 32'h80001234, 64'd7}, "R4 alt");
    check({res_hi, res_lo} === held, "R4 ignored halves", {res_hi, res_lo}, held);

    // R9: idle cycles keep the result, input changes without valid ignored
    held = {res_hi, res_lo};
    op_a = 32'h12345678; op_b = 32'h9ABCDEF0; mode = 2'b00; acc_lo = 32'h1;
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R9 idle pulse", 64'(out_valid), 64'd0);
    check({res_hi, res_lo} === held, "R9 idle hold", {res_hi, res_lo}, held);

    // R9: back-to-back requests each give a pulse and their own result
    v  = {2'b00, 3'b000, 32'h00000007, 32'hFFFFFFFE, 64'd100};
    v2 = {2'b10, 3'b001, 32'h00030004, 32'h00050006, 64'd1};
    e1 = ref_mac(v[132:131], v[130], v[129], v[128], v[127:96], v[95:64], v[63:0]);
    e2 = ref_mac(v2[132:131], v2[130], v2[129], v2[128], v2[127:96], v2[95:64], v2[63:0]);
    drive(v);
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b1, "R9 b2b first", 64'(out_valid), 64'd1);
    check({res_hi, res_lo} === e1, "R9 b2b first R1", {res_hi, res_lo}, e1);
    drive(v2);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R9 b2b second", 64'(out_valid), 64'd1);
    check({res_hi, res_lo} === e2, "R9 b2b second R6", {res_hi, res_lo}, e2);

    // random requests against the reference
    for (int i = 0; i < 400; i++) begin
      v = {2'($urandom), 3'($urandom), 32'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)};
      if (i % 8 == 0) v[127:96] = 32'h80000000;
      if (i % 8 == 1) v[95:64]  = 32'h80008000;
      run_op(v, req_of(v[132:131], v[128]));
    end

    // R10: reset mid-run blocks a pending request and clears outputs
    drive({2'b00, 3'b000, 32'h5, 32'h6, 64'd9});
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R10 mid out_valid", 64'(out_valid), 64'd0);
    check({res_hi, res_lo} === 64'd0, "R10 mid result", {res_hi, res_lo}, 64'd0);
    check(in_ready === 1'b0, "R10 mid in_ready", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    run_op({2'b01, 3'b110, 32'h80000000, 32'h80000000, 64'd0}, "R3 after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule